// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synthesizable model of a synchronous SRAM whose single bidirectional data bus can switch between reads and writes on consecutive clocks without idle cycles. Every command input (address, write enable, byte selects, chip enables, advance/load) is registered on the rising clock edge while the active-low clock enable is asserted. A read returns data within the cycle after its address edge. A write takes its data from the bus one clock after the command and updates only the byte lanes whose select was low. Each lane is eight data bits plus one parity bit.

The block drives the bus only when the current data slot belongs to a read and the asynchronous output enable is low. The bus is released during write data slots, deselected slots and reset. Deasserting the clock enable freezes the whole block, so the current slot and any output data are held. With advance/load high, the block continues the current operation at the next address of a four-beat burst. The burst order is linear or interleaved, as set by a mode input.

Top module: `zt_sram`

## Requirements
- R1: A new operation starts only at an enabled edge with adv_ld low and ce1_n low, ce2 high and ce3_n low. Any other chip-enable combination at such an edge makes the next slot deselected, and the bus is released in that slot.
- R2: A read command (we_n high) samples addr at an enabled edge. Whenever oe_n is low in the following slot, dq carries the stored word at that address.
- R3: A write command (we_n low) stores dq at the next enabled edge. It updates only lanes k with bw_n[k] low as sampled with the command. Lane k is dq[9k+8:9k], and bit 9k+8 is its parity bit.
- R4: Reads and writes may alternate on every clock. A read issued on the clock right after a write to the same address returns the newly written data.
- R5: dq is not driven during a write data slot, whatever oe_n is.
- R6: dq is not driven while oe_n is high, even in a read slot.
- R7: While cen_n is high, no state changes and no write takes place. The current slot, including any read data on dq, is held.
- R8: An enabled edge with adv_ld high continues the current read or write at the next burst address. The upper address bits are unchanged and byte selects are resampled. After a deselected slot, adv_ld high keeps the block deselected.
- R9: The two low address bits of beat n (0..3) are base+n modulo 4 when burst_mode is 0 (linear), and base XOR n when burst_mode is 1 (interleaved).
- R10: While rst_n is low the slot is deselected and dq is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | AW | Word address |
| dq | inout | LANES*9 | Data bus, lane k at bits 9k+8:9k, parity at 9k+8 |
| we_n | input | 1 | Active-low write command |
| bw_n | input | LANES | Active-low byte-lane write selects |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Asynchronous active-low output enable |
| cen_n | input | 1 | Active-low clock enable |
| adv_ld | input | 1 | 1: advance burst, 0: load new command |
| burst_mode | input | 1 | 0: linear burst order, 1: interleaved |

## Verification
The bench targets a read placed directly after a write to the same word. A design that pushed the array update one edge later would return stale data there. Stalls are placed inside write data slots, where a design that ignored cen_n for the array would capture the wrong data. Output-enable toggles land in read slots, and deselect edges are followed by advance edges. A block that drove the bus during a write slot or while disabled corrupts the bench's driven value on dq. Bursts in both orders start from unaligned bases and cross the lane-4 wrap, where a carry into the upper address bits or a swapped order reads the wrong word.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int LANES = 4,
  parameter int LW    = 9,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  inout  wire  [LANES*LW-1:0] dq,
  input  logic             we_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             oe_n,
  input  logic             cen_n,
  input  logic             adv_ld,
  input  logic             burst_mode
);
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} op_t;

  op_t              op_q;
  logic [AW-1:0]    addr_q, base_q;
  logic [1:0]       cnt_q;
  logic [LANES-1:0] bw_q;
  logic [DW-1:0]    mem [DEPTH];

  wire       sel     = !ce1_n && ce2 && !ce3_n;
  wire [1:0] cnt_nxt = cnt_q + 2'd1;
  wire [1:0] low_nxt = burst_mode ? (base_q[1:0] ^ cnt_nxt) : (base_q[1:0] + cnt_nxt);
  wire       dq_en   = (op_q == S_RD) && !oe_n;

  assign dq = dq_en ? mem[addr_q] : {DW{1'bz}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= S_IDLE;
      addr_q <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      bw_q   <= '1;
    end else if (!cen_n) begin
      if (adv_ld) begin
        if (op_q != S_IDLE) begin
          cnt_q  <= cnt_nxt;
          addr_q <= {base_q[AW-1:2], low_nxt};
          bw_q   <= bw_n;
        end
      end else if (sel) begin
        op_q   <= we_n ? S_RD : S_WR;
        addr_q <= addr;
        base_q <= addr;
        cnt_q  <= '0;
        bw_q   <= bw_n;
      end else begin
        op_q <= S_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!cen_n && op_q == S_WR)
      for (int k = 0; k < LANES; k++)
        if (!bw_q[k]) mem[addr_q][k*LW +: LW] <= dq[k*LW +: LW];
  end

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> $stable(op_q) && $stable(addr_q) && $stable(cnt_q) && $stable(bw_q));

  assert_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld && !sel) |=> op_q == S_IDLE);

  assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld && sel) |=> addr_q == $past(addr) && op_q != S_IDLE);

  assert_burst_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv_ld && op_q != S_IDLE) |=>
      op_q == $past(op_q) && addr_q[AW-1:2] == $past(addr_q[AW-1:2]) &&
      addr_q[1:0] != $past(addr_q[1:0]));

  assert_idle_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv_ld && op_q == S_IDLE) |=> op_q == S_IDLE);

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld && sel && !we_n) |=> !dq_en);
endmodule

// File: tb/sim_zt_sram.sv
module sim_zt_sram;
  localparam int LANES = 4, LW = 9, AW = 4;
  localparam int DW = LANES * LW, DEPTH = 1 << AW;
  localparam int IDLE = 0, RD = 1, WR = 2;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic we_n = 1, ce1_n = 1, ce2 = 0, ce3_n = 1, oe_n = 1, cen_n = 0, adv_ld = 0, burst_mode = 0;
  logic [LANES-1:0] bw_n = '1;
  logic tb_drv = 1;
  logic [DW-1:0] tb_data = '0;
  wire  [DW-1:0] dq_bus;
  assign dq_bus = tb_drv ? tb_data : {DW{1'bz}};

  zt_sram #(.LANES(LANES), .LW(LW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .dq(dq_bus), .we_n(we_n), .bw_n(bw_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .oe_n(oe_n), .cen_n(cen_n),
    .adv_ld(adv_ld), .burst_mode(burst_mode));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  logic partial [DEPTH];
  int m_op = IDLE;
  logic [AW-1:0] m_addr = '0, m_base = '0;
  logic [1:0] m_cnt = '0;
  logic [LANES-1:0] m_bw = '1;
  bit last_stall = 0, after_wr_same = 0;

  function automatic logic [1:0] beat_low(input logic [1:0] b, input logic [1:0] n, input logic md);
    return md ? (b ^ n) : (b + n);
  endfunction

  function automatic string pick_tag();
    if (last_stall) return "R7";
    if (m_op == IDLE) return "R1";
    if (m_op == WR) return "R5";
    if (oe_n) return "R6";
    if (after_wr_same) return "R4";
    if (m_cnt != 0) return burst_mode ? "R9" : "R8";
    if (partial[m_addr]) return "R3";
    return "R2";
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dq=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit cen, input bit adv, input bit we, input logic [LANES-1:0] bw,
                     input int dsel, input logic [AW-1:0] a, input bit oe);
    bit exp_drv;
    logic [1:0] nl;
    @(negedge clk);
    cen_n = cen; adv_ld = adv; we_n = we; bw_n = bw; addr = a; oe_n = oe;
    ce1_n = (dsel == 1); ce2 = (dsel != 2); ce3_n = (dsel == 3);
    exp_drv = (m_op == RD) && !oe;
    tb_drv = !exp_drv;
    tb_data = (m_op == WR) ? {$urandom, $urandom} : '0;
    #2;
    check(pick_tag(), dq_bus, exp_drv ? ref_mem[m_addr] : tb_data);
    @(posedge clk);
    last_stall = cen;
    after_wr_same = 0;
    if (!cen) begin
      if (m_op == WR)
        for (int k = 0; k < LANES; k++)
          if (!m_bw[k]) ref_mem[m_addr][k*LW +: LW] = tb_data[k*LW +: LW];
      if (m_op == WR) partial[m_addr] = (m_bw != '0);
      if (adv) begin
        if (m_op != IDLE) begin
          m_cnt = m_cnt + 2'd1;
          nl = beat_low(m_base[1:0], m_cnt, burst_mode);
          m_addr = {m_base[AW-1:2], nl};
          m_bw = bw;
        end
      end else if (dsel == 0) begin
        after_wr_same = (m_op == WR) && (m_addr == a) && we;
        m_op = we ? RD : WR; m_addr = a; m_base = a; m_cnt = 0; m_bw = bw;
      end else m_op = IDLE;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) partial[i] = 0;
    oe_n = 0; tb_drv = 1; tb_data = '0;
    repeat (3) @(negedge clk);
    #2 check("R10", dq_bus, '0);
    rst_n = 1;
    // fill every word with full-lane writes
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, '0, 0, AW'(i), 0);
    cyc(0, 0, 1, '1, 1, '0, 0);
    // alternating write/read on the same word
    for (int i = 0; i < 6; i++) begin
      cyc(0, 0, 0, '0, 0, AW'(i), 0);
      cyc(0, 0, 1, '1, 0, AW'(i), 0);
    end
    // byte-masked write then read back
    cyc(0, 0, 0, 4'b1010, 0, 4'd9, 0);
    cyc(0, 0, 1, '1, 0, 4'd9, 0);
    cyc(0, 0, 0, 4'b0110, 0, 4'd9, 1);
    cyc(0, 0, 1, '1, 2, 4'd0, 0);
    cyc(0, 0, 1, '1, 0, 4'd9, 0);
    // stall inside a write data slot and inside a read slot
    cyc(0, 0, 0, '0, 0, 4'd5, 0);
    cyc(1, 0, 1, '1, 0, 4'd1, 0);
    cyc(1, 0, 1, '1, 0, 4'd1, 0);
    cyc(0, 0, 1, '1, 0, 4'd5, 0);
    cyc(1, 0, 0, '0, 0, 4'd2, 0);
    cyc(1, 0, 0, '0, 0, 4'd2, 0);
    cyc(0, 0, 1, '1, 3, 4'd2, 0);
    // advance after deselect stays deselected
    cyc(0, 1, 1, '1, 0, 4'd3, 0);
    cyc(0, 1, 0, '0, 0, 4'd3, 0);
    // linear burst from base 2, then interleaved from base 13
    burst_mode = 0;
    cyc(0, 0, 0, '0, 0, 4'd2, 0);
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, '0, 0, '0, 0);
    cyc(0, 0, 1, '1, 0, 4'd2, 0);
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, '1, 0, '0, 0);
    cyc(0, 0, 1, '1, 1, '0, 0);
    burst_mode = 1;
    cyc(0, 0, 0, '0, 0, 4'd13, 0);
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, '0, 0, '0, 0);
    cyc(0, 0, 1, '1, 0, 4'd13, 0);
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, '1, 0, '0, 0);
    cyc(0, 0, 1, '1, 1, '0, 1);
    // constrained random traffic in both burst orders
    for (int ph = 0; ph < 2; ph++) begin
      burst_mode = ph[0];
      for (int i = 0; i < 2000; i++) begin
        bit c, v, w, o;
        int d;
        c = ($urandom % 8) == 0;
        v = ($urandom % 3) == 0;
        w = ($urandom % 2) == 0;
        o = ($urandom % 8) == 0;
        d = (($urandom % 8) == 0) ? 1 + ($urandom % 3) : 0;
        cyc(c, v, w, LANES'($urandom), d, AW'($urandom), o);
      end
      cyc(0, 0, 1, '1, 1, '0, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule